// File: doc/BRIEF.md
# Serial Port Interrupt Controller

This block gathers the interrupt conditions of a synchronous serial port and turns them into status bits, per-source interrupt lines and one combined request. Seven sources are handled. Two are live level conditions taken from the transmit and receive FIFO fill levels. One comes from a receive time-out counter that watches for data left waiting in the receive FIFO. Four are sticky event bits: receive overrun, end of transmission, receive DMA complete and transmit DMA complete. Each sticky bit is set by a one-cycle pulse from the neighbouring logic.

Software reaches the block through a small register bus with separate write and read strobes. There is an enable mask, a raw status view, a masked status view and a write-one-to-clear register. The time-out counter counts serial clock periods, and each period is marked by a one-cycle tick input. A write into the receive FIFO restarts the count. An empty receive FIFO forces the count and the time-out bit back to zero.

Top module: `ssp_irq_ctrl`

## Requirements
- R1: Source bit 0 (transmit service) equals `tx_level <= FIFO_DEPTH/2` in the same cycle, with no register in the path. Writing 1 to clear bit 0 has no effect on it.
- R2: Source bit 1 (receive service) equals `rx_level >= FIFO_DEPTH/2` in the same cycle. Writing 1 to clear bit 1 has no effect on it.
- R3: Source bit 2 (receive time-out) becomes 1 one cycle after the `tmo_tick` that completes TMO_PERIODS ticks. The ticks are counted while the receive FIFO is non-empty, with no receive write and no clear of bit 2 since the count started. The count starts when the FIFO becomes non-empty.
- R4: A cycle with `rx_push` high restarts the time-out count from zero. It does not set bit 2 in that cycle. It leaves an already-set bit 2 unchanged.
- R5: Bit 2 and the count return to 0 in any cycle where `rx_level` is 0, and also on a write of 1 to clear bit 2. After such a clear, if data remains, bit 2 sets again after another TMO_PERIODS ticks.
- R6: Bits 3 (overrun), 5 (receive DMA done) and 6 (transmit DMA done) are sticky. Each sets the cycle after its pulse and clears the cycle after a write of 1 to its clear bit. If a pulse and a clear fall in the same cycle, the bit ends up set.
- R7: Bit 4 (end of transmission) behaves like R6 while `master_mode` is 1. In any cycle with `master_mode` at 0 it is forced to 0 on the next edge, and the pulse is ignored.
- R8: The mask register sits at address 0 and has one enable bit per source; 1 enables the source. Masked status `irq_src_o` is raw status AND mask. `irq_o` is the OR of the masked bits.
- R9: Register map: address 0 is the mask (read/write), address 1 is raw status, address 2 is masked status, and address 3 is the clear register (write-one-to-clear, reads 0). Read data is bits [6:0] zero-extended. It is captured on the edge where `bus_rd` is high and shows state from before that edge. It holds otherwise.
- R10: Asynchronous reset clears the mask, all sticky bits, the time-out bit, the count and the read data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_level | input | LVL_W | Transmit FIFO entry count |
| rx_level | input | LVL_W | Receive FIFO entry count |
| rx_push | input | 1 | Receive FIFO write strobe |
| tmo_tick | input | 1 | One-cycle marker per serial clock period |
| master_mode | input | 1 | 1 when the port is the bus master |
| ovf_pulse | input | 1 | Receive overrun event |
| eot_pulse | input | 1 | End-of-transmission event |
| rx_dma_done | input | 1 | Receive DMA complete event |
| tx_dma_done | input | 1 | Transmit DMA complete event |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Registered read data |
| raw_o | output | 7 | Raw status per source |
| irq_src_o | output | 7 | Masked per-source interrupt lines |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Two kinds of same-cycle collision matter most. The first is a software clear landing on a sticky bit in the very cycle its event pulse arrives. The second is a receive write, or a time-out clear, landing on the tick that would have expired the count. Directed phases place a clear write exactly on a pulse cycle and put `rx_push` on the 32nd tick. A long random phase then overlaps ticks, pushes, clears and pulses freely. A behavioural reference model judges every cycle: the set must win for sticky bits, while a push or a time-out clear must keep bit 2 low and restart the count.

// File: rtl/ssp_irq_pkg.sv
package ssp_irq_pkg;
  localparam int NSRC = 7;

  typedef logic [NSRC-1:0] src_vec_t;

  // Bit positions of the sources in every status view
  typedef enum int {
    SRC_TXSVC = 0,
    SRC_RXSVC = 1,
    SRC_RXTMO = 2,
    SRC_RXOVF = 3,
    SRC_EOT   = 4,
    SRC_RXDMA = 5,
    SRC_TXDMA = 6
  } src_e;

  // First of the contiguous event-driven sticky sources and their count
  localparam int STK_BASE = 3;
  localparam int STK_NUM  = 4;

  localparam logic [1:0] ADR_MASK = 2'd0;
  localparam logic [1:0] ADR_RAW  = 2'd1;
  localparam logic [1:0] ADR_MSK  = 2'd2;
  localparam logic [1:0] ADR_CLR  = 2'd3;
endpackage

// File: rtl/ssp_irq_rxtmo.sv
module ssp_irq_rxtmo #(
  parameter int LVL_W   = 4,
  parameter int PERIODS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             rx_push,
  input  logic             tick,
  input  logic             clr_i,
  output logic             flag_o
);
  localparam int               CNT_W   = $clog2(PERIODS + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(PERIODS);
  localparam logic [CNT_W-1:0] CNT_LST = CNT_W'(PERIODS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             flag_q, flag_d, flag_en;
  logic             rx_empty, restart, expire;

  assign rx_empty = (rx_level == '0);
  assign restart  = rx_empty | rx_push | clr_i;
  assign expire   = tick & ~restart & (cnt_q == CNT_LST);

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (restart) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (tick && (cnt_q != CNT_END)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_comb begin
    flag_en = 1'b0;
    flag_d  = flag_q;
    if (rx_empty || clr_i) begin
      flag_en = flag_q;
      flag_d  = 1'b0;
    end else if (expire) begin
      flag_en = 1'b1;
      flag_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

  AST_TMO_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_END); // R3
  AST_TMO_PUSH_NOSET: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && !flag_q) |=> !flag_q); // R4
  AST_TMO_EMPTY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level == '0) |=> (!flag_q && cnt_q == '0)); // R5
endmodule

// File: rtl/ssp_irq_status.sv
module ssp_irq_status
  import ssp_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int LVL_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             master_mode,
  input  logic             ovf_pulse,
  input  logic             eot_pulse,
  input  logic             rx_dma_done,
  input  logic             tx_dma_done,
  input  src_vec_t         clr_i,
  input  logic             tmo_i,
  output src_vec_t         raw_o
);
  localparam logic [LVL_W-1:0] HALF = LVL_W'(FIFO_DEPTH / 2);

  logic [STK_NUM-1:0] stk_set;
  logic [STK_NUM-1:0] stk_q;
  logic               tx_svc, rx_svc;

  // Event pulses in the order of their bit positions
  assign stk_set = {tx_dma_done, rx_dma_done, eot_pulse, ovf_pulse};

  assign tx_svc = (tx_level <= HALF);
  assign rx_svc = (rx_level >= HALF);

  for (genvar i = 0; i < STK_NUM; i++) begin : g_stk
    localparam int  IDX   = STK_BASE + i;
    localparam bit  IS_EOT = (IDX == SRC_EOT);
    logic stk_d, stk_en, kill;

    assign kill = IS_EOT ? ~master_mode : 1'b0;

    always_comb begin
      stk_en = 1'b0;
      stk_d  = stk_q[i];
      if (kill) begin
        stk_en = stk_q[i];
        stk_d  = 1'b0;
      end else if (stk_set[i]) begin
        stk_en = 1'b1;
        stk_d  = 1'b1;
      end else if (clr_i[IDX]) begin
        stk_en = stk_q[i];
        stk_d  = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stk_q[i] <= 1'b0;
      end else if (stk_en) begin
        stk_q[i] <= stk_d;
      end
    end
  end

  always_comb begin
    raw_o            = '0;
    raw_o[SRC_TXSVC] = tx_svc;
    raw_o[SRC_RXSVC] = rx_svc;
    raw_o[SRC_RXTMO] = tmo_i;
    raw_o[NSRC-1:STK_BASE] = stk_q;
  end

  AST_OVF_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |=> raw_o[SRC_RXOVF]); // R6
  AST_TXDMA_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i[SRC_TXDMA] && !tx_dma_done) |=> !raw_o[SRC_TXDMA]); // R6
  AST_EOT_SLAVE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !master_mode |=> !raw_o[SRC_EOT]); // R7
endmodule

// File: rtl/ssp_irq_regs.sv
module ssp_irq_regs
  import ssp_irq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  input  src_vec_t          raw_i,
  output src_vec_t          mask_o,
  output src_vec_t          clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  src_vec_t          mask_q, mask_d;
  logic              mask_en;
  logic [DATA_W-1:0] rd_sel;
  logic [DATA_W-1:0] rdata_q;

  assign mask_en = bus_wr & (bus_addr == ADR_MASK);
  assign mask_d  = bus_wdata[NSRC-1:0];
  assign clr_o   = (bus_wr && bus_addr == ADR_CLR) ? bus_wdata[NSRC-1:0] : '0;

  always_comb begin
    rd_sel = '0;
    case (bus_addr)
      ADR_MASK: rd_sel[NSRC-1:0] = mask_q;
      ADR_RAW:  rd_sel[NSRC-1:0] = raw_i;
      ADR_MSK:  rd_sel[NSRC-1:0] = raw_i & mask_q;
      default:  rd_sel = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      rdata_q <= rd_sel;
    end
  end

  assign mask_o  = mask_q;
  assign rdata_o = rdata_q;

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == ADR_MASK) |=> $stable(mask_q)); // R8
  AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADR_CLR) |=> (rdata_q == '0)); // R9
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(rdata_q)); // R9
endmodule

// File: rtl/ssp_irq_ctrl.sv
module ssp_irq_ctrl
  import ssp_irq_pkg::*;
#(
  parameter int FIFO_DEPTH  = 8,
  parameter int LVL_W       = $clog2(FIFO_DEPTH + 1),
  parameter int TMO_PERIODS = 32,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic              rx_push,
  input  logic              tmo_tick,
  input  logic              master_mode,
  input  logic              ovf_pulse,
  input  logic              eot_pulse,
  input  logic              rx_dma_done,
  input  logic              tx_dma_done,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [6:0]        raw_o,
  output logic [6:0]        irq_src_o,
  output logic              irq_o
);
  src_vec_t raw, mask, clr;
  logic     tmo_flag;

  ssp_irq_regs #(.DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .bus_rd   (bus_rd),
    .raw_i    (raw),
    .mask_o   (mask),
    .clr_o    (clr),
    .rdata_o  (bus_rdata)
  );

  ssp_irq_rxtmo #(.LVL_W(LVL_W), .PERIODS(TMO_PERIODS)) u_rxtmo (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_level(rx_level),
    .rx_push (rx_push),
    .tick    (tmo_tick),
    .clr_i   (clr[SRC_RXTMO]),
    .flag_o  (tmo_flag)
  );

  ssp_irq_status #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_level   (tx_level),
    .rx_level   (rx_level),
    .master_mode(master_mode),
    .ovf_pulse  (ovf_pulse),
    .eot_pulse  (eot_pulse),
    .rx_dma_done(rx_dma_done),
    .tx_dma_done(tx_dma_done),
    .clr_i      (clr),
    .tmo_i      (tmo_flag),
    .raw_o      (raw)
  );

  assign raw_o     = raw;
  assign irq_src_o = raw & mask;
  assign irq_o     = |irq_src_o;

  AST_IRQ_MASKED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq_o); // R8
  AST_SRC_NEEDS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_src_o & ~raw_o) == '0)); // R8
endmodule

// File: tb/ssp_irq_ctrl_bench.sv
module ssp_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8;
  localparam int HALF       = DEPTH / 2;
  localparam int TMO        = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] tx_level = '0, rx_level = '0;
  logic       rx_push = 0, tmo_tick = 0, master_mode = 0;
  logic       ovf_pulse = 0, eot_pulse = 0, rx_dma_done = 0, tx_dma_done = 0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [6:0] raw_o, irq_src_o;
  logic       irq_o;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;
  string phase = "R10";

  ssp_irq_ctrl u_ssp_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .tx_level(tx_level), .rx_level(rx_level),
    .rx_push(rx_push), .tmo_tick(tmo_tick), .master_mode(master_mode),
    .ovf_pulse(ovf_pulse), .eot_pulse(eot_pulse), .rx_dma_done(rx_dma_done),
    .tx_dma_done(tx_dma_done), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .raw_o(raw_o), .irq_src_o(irq_src_o), .irq_o(irq_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // Reference model state
  bit [6:0] m_mask;
  bit       m_ovf, m_eot, m_rxd, m_txd, m_tmo;
  int       m_elapsed;
  bit [7:0] m_rd;

  function automatic bit [6:0] m_raw();
    bit [6:0] r;
    r[0] = (int'(tx_level) <= HALF);
    r[1] = (int'(rx_level) >= HALF);
    r[2] = m_tmo;
    r[3] = m_ovf;
    r[4] = m_eot;
    r[5] = m_rxd;
    r[6] = m_txd;
    return r;
  endfunction

  function automatic string bit_req(int b);
    case (b)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      4: return "R7";
      default: return "R6";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mask = '0; m_ovf = 0; m_eot = 0; m_rxd = 0; m_txd = 0;
      m_tmo = 0; m_elapsed = 0; m_rd = '0;
    end else begin
      bit [6:0] clr, rv;
      bit       empty;
      clr   = (bus_wr && bus_addr == 2'd3) ? bus_wdata[6:0] : 7'd0;
      rv    = m_raw();
      empty = (rx_level == 0);
      if (bus_rd) begin
        case (bus_addr)
          2'd0: m_rd = {1'b0, m_mask};
          2'd1: m_rd = {1'b0, rv};
          2'd2: m_rd = {1'b0, rv & m_mask};
          default: m_rd = 8'd0;
        endcase
      end
      if (ovf_pulse) m_ovf = 1; else if (clr[3]) m_ovf = 0;
      if (rx_dma_done) m_rxd = 1; else if (clr[5]) m_rxd = 0;
      if (tx_dma_done) m_txd = 1; else if (clr[6]) m_txd = 0;
      if (!master_mode) m_eot = 0; else if (eot_pulse) m_eot = 1; else if (clr[4]) m_eot = 0;
      if (empty || clr[2]) m_tmo = 0;
      else if (!rx_push && tmo_tick && m_elapsed == TMO - 1) m_tmo = 1;
      if (empty || rx_push || clr[2]) m_elapsed = 0;
      else if (tmo_tick && m_elapsed < TMO) m_elapsed++;
      if (bus_wr && bus_addr == 2'd0) m_mask = bus_wdata[6:0];
    end
  end

  task automatic compare();
    bit [6:0] rv;
    bit [6:0] mv;
    rv = m_raw();
    mv = rv & m_mask;
    vectors++;
    for (int b = 0; b < 7; b++) begin
      if (raw_o[b] !== rv[b]) begin
        fails++;
        $display("FAIL %s (phase %s) raw bit %0d act=%b exp=%b t=%0t",
                 bit_req(b), phase, b, raw_o[b], rv[b], $time);
      end
    end
    if (irq_src_o !== mv || irq_o !== (|mv)) begin
      fails++;
      $display("FAIL R8 (phase %s) masked act=%h/%b exp=%h/%b t=%0t",
               phase, irq_src_o, irq_o, mv, |mv, $time);
    end
    if (bus_rdata !== m_rd) begin
      fails++;
      $display("FAIL R9 (phase %s) rdata act=%h exp=%h t=%0t",
               phase, bus_rdata, m_rd, $time);
    end
  endtask

  // One cycle: check at the falling edge, then clear strobes for the caller
  task automatic step();
    @(negedge clk);
    compare();
    rx_push = 0; tmo_tick = 0; ovf_pulse = 0; eot_pulse = 0;
    rx_dma_done = 0; tx_dma_done = 0; bus_wr = 0; bus_rd = 0;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wr = 1; bus_wdata = d;
    step();
  endtask

  task automatic rd_reg(input logic [1:0] a);
    bus_addr = a; bus_rd = 1;
    step();
    step();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tmo_tick = 1;
      step();
    end
  endtask

  initial begin
    repeat (3) step();           // R10 reset values
    rst_n = 1;
    step();

    phase = "R8";
    wr_reg(2'd0, 8'h7F);
    rd_reg(2'd0);
    wr_reg(2'd0, 8'h15);
    rd_reg(2'd2);
    wr_reg(2'd0, 8'h7F);

    phase = "R1";
    for (int l = 0; l <= DEPTH; l++) begin
      tx_level = 4'(l); rx_level = 4'(DEPTH - l);
      wr_reg(2'd3, 8'h03);       // clears of level bits have no effect
      step();
    end

    phase = "R3";
    rx_level = 4'd3;
    ticks(TMO + 4);
    rd_reg(2'd1);
    phase = "R4";
    rx_level = 4'd0; step();
    rx_level = 4'd2;
    ticks(20);
    rx_push = 1; step();
    ticks(TMO - 1);
    rx_push = 1; tmo_tick = 1; step();   // push on the expiring tick
    ticks(TMO + 1);
    phase = "R5";
    bus_addr = 2'd3; bus_wr = 1; bus_wdata = 8'h04; tmo_tick = 1; step();
    ticks(10);
    for (int i = 0; i < 3 * TMO; i++) begin
      tmo_tick = (i % 3 == 0);
      step();
    end
    rx_level = 4'd0; step(); step();

    phase = "R6";
    ovf_pulse = 1; rx_dma_done = 1; tx_dma_done = 1; step();
    wr_reg(2'd3, 8'h68);
    ovf_pulse = 1; step();
    ovf_pulse = 1; bus_addr = 2'd3; bus_wr = 1; bus_wdata = 8'h48;
    tx_dma_done = 1; step();             // set and clear together
    wr_reg(2'd3, 8'h7F);

    phase = "R7";
    master_mode = 0; eot_pulse = 1; step();
    master_mode = 1; eot_pulse = 1; step();
    step();
    master_mode = 0; step();
    master_mode = 1; eot_pulse = 1; step();
    eot_pulse = 1; bus_addr = 2'd3; bus_wr = 1; bus_wdata = 8'h10; step();
    wr_reg(2'd3, 8'h10);

    phase = "R9";
    for (int a = 0; a < 4; a++) rd_reg(2'(a));

    phase = "random";
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 15) == 0) tx_level = 4'($urandom_range(0, DEPTH));
      if ($urandom_range(0, 63) == 0) rx_level = 4'($urandom_range(0, DEPTH));
      rx_push     = ($urandom_range(0, 11) == 0);
      tmo_tick    = ($urandom_range(0, 1) == 0);
      ovf_pulse   = ($urandom_range(0, 40) == 0);
      eot_pulse   = ($urandom_range(0, 30) == 0);
      rx_dma_done = ($urandom_range(0, 35) == 0);
      tx_dma_done = ($urandom_range(0, 35) == 0);
      if ($urandom_range(0, 200) == 0) master_mode = ~master_mode;
      bus_addr  = 2'($urandom_range(0, 3));
      bus_wr    = ($urandom_range(0, 12) == 0);
      bus_wdata = 8'($urandom);
      bus_rd    = ($urandom_range(0, 3) == 0);
      step();
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired t=%0t", $time);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule